// File: doc/BRIEF.md
# Disk Drive Control and Status Registers

This block holds the two host-visible registers that sit between a floppy-style drive port and a register bus. A read/write control register sets the drive-select code, four spindle motor enables, a DMA enable and an active-low soft-reset bit. A read-only status register reports recent activity on three drive-port signals and the current state of the two supported drive-select lines.

The three monitored signals are write-gate, read-data and write-data. Each passes through a two-flop synchronizer and an edge detector. The detected event sets a sticky bit. The write-gate bit is set on its asserting edge. The read-data and write-data bits are set on their deasserting edges. A read of the status register clears all three sticky bits. If a new event lands in the same cycle as the read, that event is kept for the next read.

Writing 0 to the reset bit asserts `ctrl_rst`. The output stays asserted after the bit returns to 1, so that every soft reset lasts at least `RST_MIN_CYC` clock cycles. The default of 20 cycles gives 100 ns with a 5 ns clock. Bus accesses are single-cycle strobes, and read data is registered.

Top module: `fdc_drive_regs`

## Requirements
- R1: After `rst_n` is released, the control register reads 0x00 and `motor_en`, `dma_en` and the status sticky bits are all 0. `ctrl_rst` is 1 and `drv_sel_n` is 2'b10.
- R2: A `bus_wr` with `bus_addr`=1 loads `bus_wdata` into the control register at that clock edge. The fields are bits 7:4 = `motor_en[3:0]`, bit 3 = `dma_en`, bit 2 = active-low reset and bits 1:0 = drive-select code. Without such a write the register does not change.
- R3: `drv_sel_n` is active low and decoded from the drive-select code. Code 0 gives 2'b10, code 1 gives 2'b01, and codes 2 and 3 give 2'b11. At most one line is low at any time.
- R4: `ctrl_rst` is 1 whenever control bit 2 is 0. The soft reset never alters any control register bit.
- R5: A write of 0 to bit 2 followed by a write of 1 on the very next cycle keeps `ctrl_rst` high for exactly `RST_MIN_CYC` cycles, counted from the cycle after the first write.
- R6: A rising edge on `wgate_in` sets status bit 2. A falling edge on `rdata_in` sets bit 3. A falling edge on `wdata_in` sets bit 4, whatever the level of `wgate_in`. The bit is set at the third clock edge after the input changes.
- R7: A read with `bus_addr`=0 returns the sticky bits as they were before that edge and clears them. An event that sets a bit in the same cycle as the read leaves that bit at 1. Otherwise the sticky bits hold.
- R8: In the status byte, bit 7 is 0 and bits 1:0 are 2'b11. Bits 6:5 equal `drv_sel_n[1:0]`.
- R9: `bus_rdata` takes the addressed register at the edge where `bus_rd` is high and holds its value in every other cycle. A write with `bus_addr`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 1 | 0 = status register, 1 = control register |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wgate_in | input | 1 | Write-gate activity from the drive port (asynchronous) |
| rdata_in | input | 1 | Read-data activity from the drive port (asynchronous) |
| wdata_in | input | 1 | Write-data activity from the drive port (asynchronous) |
| drv_sel_n | output | 2 | Active-low drive selects for drives 0 and 1 |
| motor_en | output | 4 | Motor enables, drives 3..0 |
| dma_en | output | 1 | DMA enable |
| ctrl_rst | output | 1 | Stretched controller soft reset, active high |

## Verification
A wrong control register value appears on `motor_en`, `dma_en` or `drv_sel_n` in the very next cycle after the write edge, and `ctrl_rst` shows the same error through its reset bit. A stretch counter that is off by one makes the reset pulse one cycle too short or too long, and this is seen only when the pulse ends. A fault in a synchronizer stage or an edge detector stays hidden until the next status read. It then shows as a wrong bit in `bus_rdata` one cycle after the read strobe. A missed clear or a lost same-cycle event shows on the read after that.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int NMON   = 3;  // monitored drive-port signals
  localparam int MON_WG = 0;  // write gate, rising edge
  localparam int MON_RD = 1;  // read data, falling edge
  localparam int MON_WD = 2;  // write data, falling edge

  localparam int NSEL   = 2;  // supported drive selects

  typedef struct packed {
    logic [3:0] motor;
    logic       dma;
    logic       nrst;
    logic [1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/fdr_edge_mon.sv
module fdr_edge_mon #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic evt
);
  logic s1_q, s2_q, s3_q;
  logic s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = sig_in;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign evt = s2_q & ~s3_q;
    end else begin : g_fall
      assign evt = ~s2_q & s3_q;
    end
  endgenerate

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);  // R6
endmodule

// File: rtl/fdr_ctrl_reg.sv
module fdr_ctrl_reg
  import fdr_pkg::*;
#(
  parameter int RST_MIN_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  output ctrl_t           ctrl,
  output logic            ctrl_rst,
  output logic [NSEL-1:0] drv_sel_n
);
  localparam int CNT_W = (RST_MIN_CYC < 2) ? 1 : $clog2(RST_MIN_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_MIN_CYC - 1);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_busy;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(wdata);
  end

  assign cnt_busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!ctrl_q.nrst)  cnt_d = CNT_LOAD;
    else if (cnt_busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= CNT_LOAD;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign ctrl_rst = ~ctrl_q.nrst | cnt_busy;

  genvar gi;
  generate
    for (gi = 0; gi < NSEL; gi++) begin : g_sel
      assign drv_sel_n[gi] = (ctrl_q.sel != 2'(gi));
    end
  endgenerate

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));  // R2
  AST_RST_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst) |=> ctrl_rst);  // R5
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst) |-> ctrl_q.nrst);  // R4
endmodule

// File: rtl/fdr_status.sv
module fdr_status
  import fdr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMON-1:0] set,
  input  logic            rd_clr,
  output logic [NMON-1:0] sticky
);
  logic [NMON-1:0] sticky_q, sticky_d;

  always_comb begin
    sticky_d = rd_clr ? '0 : sticky_q;
    sticky_d = sticky_d | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  assign sticky = sticky_q;

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));  // R7
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set == '0) |=> sticky_q == '0);  // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((sticky_q & $past(set)) == $past(set)));  // R6
endmodule

// File: rtl/fdc_drive_regs.sv
module fdc_drive_regs
  import fdr_pkg::*;
#(
  parameter int RST_MIN_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wgate_in,
  input  logic       rdata_in,
  input  logic       wdata_in,
  output logic [1:0] drv_sel_n,
  output logic [3:0] motor_en,
  output logic       dma_en,
  output logic       ctrl_rst
);
  localparam bit [NMON-1:0] RISE_MASK = NMON'(1 << MON_WG);

  logic [NMON-1:0] mon_in, mon_evt, sticky;
  ctrl_t           ctrl;
  logic [NSEL-1:0] sel_n;
  logic            ctrl_wr, stat_rd;
  logic [7:0]      stat_byte, rdata_q, rdata_d;

  assign mon_in[MON_WG] = wgate_in;
  assign mon_in[MON_RD] = rdata_in;
  assign mon_in[MON_WD] = wdata_in;

  genvar gm;
  generate
    for (gm = 0; gm < NMON; gm++) begin : g_mon
      fdr_edge_mon #(.RISE(RISE_MASK[gm])) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (mon_in[gm]),
        .evt    (mon_evt[gm])
      );
    end
  endgenerate

  assign ctrl_wr = bus_wr & (bus_addr == ADDR_CTRL);
  assign stat_rd = bus_rd & (bus_addr == ADDR_STAT);

  fdr_ctrl_reg #(.RST_MIN_CYC(RST_MIN_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wdata     (bus_wdata),
    .ctrl      (ctrl),
    .ctrl_rst  (ctrl_rst),
    .drv_sel_n (sel_n)
  );

  fdr_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (mon_evt),
    .rd_clr (stat_rd),
    .sticky (sticky)
  );

  always_comb begin
    stat_byte      = 8'h03;
    stat_byte[6:5] = sel_n;
    stat_byte[4]   = sticky[MON_WD];
    stat_byte[3]   = sticky[MON_RD];
    stat_byte[2]   = sticky[MON_WG];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = (bus_addr == ADDR_CTRL) ? 8'(ctrl) : stat_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign drv_sel_n = sel_n;
  assign motor_en  = ctrl.motor;
  assign dma_en    = ctrl.dma;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~drv_sel_n));  // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));  // R9
  AST_STAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_STAT) |=> (bus_rdata[7] == 1'b0 && bus_rdata[1:0] == 2'b11));  // R8
endmodule

// File: tb/sim_fdc_drive_regs.sv
module sim_fdc_drive_regs;
  localparam int MIN = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       wgate_in = 1'b0, rdata_in = 1'b0, wdata_in = 1'b0;
  logic [7:0] bus_rdata;
  logic [1:0] drv_sel_n;
  logic [3:0] motor_en;
  logic       dma_en, ctrl_rst;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fdc_drive_regs #(.RST_MIN_CYC(MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wgate_in(wgate_in), .rdata_in(rdata_in), .wdata_in(wdata_in),
    .drv_sel_n(drv_sel_n), .motor_en(motor_en), .dma_en(dma_en),
    .ctrl_rst(ctrl_rst)
  );

  // behavioural reference model
  logic [7:0] m_ctrl, m_rdata;
  logic [2:0] m_st;
  int         m_hold;
  bit         hw[3], hr[3], hd[3];

  function automatic logic [1:0] exp_sel(logic [7:0] c);
    case (c[1:0])
      2'd0:    return 2'b10;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(logic [7:0] c, logic [2:0] s);
    logic [1:0] sl;
    sl = exp_sel(c);
    return {1'b0, sl[1], sl[0], s[2], s[1], s[0], 2'b11};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_rdata <= '0; m_st <= '0; m_hold <= MIN - 1;
      for (int i = 0; i < 3; i++) begin hw[i] <= 0; hr[i] <= 0; hd[i] <= 0; end
    end else begin
      logic [2:0] ev, nst;
      ev[0] = hw[1] && !hw[2];
      ev[1] = !hr[1] && hr[2];
      ev[2] = !hd[1] && hd[2];
      nst = (bus_rd && !bus_addr) ? 3'b000 : m_st;
      m_st <= nst | ev;
      if (bus_rd) m_rdata <= bus_addr ? m_ctrl : exp_stat(m_ctrl, m_st);
      if (bus_wr && bus_addr) m_ctrl <= bus_wdata;
      if (!m_ctrl[2]) m_hold <= MIN - 1;
      else if (m_hold > 0) m_hold <= m_hold - 1;
      hw[2] <= hw[1]; hw[1] <= hw[0]; hw[0] <= wgate_in;
      hr[2] <= hr[1]; hr[1] <= hr[0]; hr[0] <= rdata_in;
      hd[2] <= hd[1]; hd[1] <= hd[0]; hd[0] <= wdata_in;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 motor", {4'b0, motor_en}, {4'b0, m_ctrl[7:4]});
      check("R2 dma", {7'b0, dma_en}, {7'b0, m_ctrl[3]});
      check("R3 sel", {6'b0, drv_sel_n}, {6'b0, exp_sel(m_ctrl)});
      check("R4/R5 ctrl_rst", {7'b0, ctrl_rst}, {7'b0, (!m_ctrl[2] || m_hold != 0)});
      check("R9/R7 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl_rst", {7'b0, ctrl_rst}, 8'd1);
    check("R1 sel", {6'b0, drv_sel_n}, 8'b10);
    check("R1 motor", {4'b0, motor_en}, 8'h0);
    rd(1); check("R1 ctrl readback", bus_rdata, 8'h00);
    rd(0); check("R1/R8 status", bus_rdata, 8'h43);

    // R2 field mapping and readback
    wr(1, 8'hA5); rd(1); check("R2 readback", bus_rdata, 8'hA5);
    check("R2 motor", {4'b0, motor_en}, 8'h0A);
    check("R3 code1", {6'b0, drv_sel_n}, 8'b01);
    wr(1, 8'h06); check("R3 code2", {6'b0, drv_sel_n}, 8'b11);
    rd(0); check("R8 status sel bits", bus_rdata, 8'h63);
    // R9 write to status address ignored
    wr(0, 8'hFF); rd(1); check("R9 status write ignored", bus_rdata, 8'h06);

    // R5 back-to-back soft reset pulse
    wr(1, 8'h04);
    repeat (MIN + 2) @(negedge clk);
    bus_addr = 1; bus_wr = 1; bus_wdata = 8'h10;
    @(negedge clk); cnt = ctrl_rst ? 1 : 0; bus_wdata = 8'h14;
    @(negedge clk); bus_wr = 0;
    while (ctrl_rst && cnt < 10 * MIN) begin cnt++; @(negedge clk); end
    check("R5 stretch length", 8'(cnt), 8'(MIN));
    rd(1); check("R4 bits unchanged by soft reset", bus_rdata, 8'h14);

    // R6 edges, R7 clear and same-cycle event
    rd(0);
    wgate_in = 1; repeat (4) @(negedge clk);
    rdata_in = 1; repeat (4) @(negedge clk); rdata_in = 0;
    repeat (4) @(negedge clk);
    rd(0); check("R6 wgate rise/rdata fall", bus_rdata & 8'h1C, 8'h0C);
    rd(0); check("R7 cleared", bus_rdata & 8'h1C, 8'h00);
    wgate_in = 0; wdata_in = 1; repeat (4) @(negedge clk);
    wdata_in = 0; repeat (4) @(negedge clk);
    rd(0); check("R6 wdata fall without gate", bus_rdata & 8'h1C, 8'h10);
    // event arriving at the same edge as the read
    @(negedge clk); wgate_in = 1;
    @(negedge clk);
    @(negedge clk); bus_addr = 0; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    check("R7 read returns old value", bus_rdata & 8'h04, 8'h00);
    rd(0); check("R7 same-cycle event kept", bus_rdata & 8'h04, 8'h04);

    // random traffic, compared against the model every clock
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) wgate_in = ~wgate_in;
      if ($urandom % 3 == 0) rdata_in = ~rdata_in;
      if ($urandom % 3 == 0) wdata_in = ~wdata_in;
      bus_addr  = 1'($urandom);
      bus_rd    = ($urandom % 3 == 0);
      bus_wr    = ($urandom % 9 == 0);
      bus_wdata = 8'($urandom);
      if ($urandom % 5 != 0) bus_wdata[2] = 1'b1;
    end
    @(negedge clk); bus_rd = 0; bus_wr = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule